// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Selectable Read-During-Write

The block is a synchronous simple-dual-port RAM: one write port and one read port, both on the same clock. All write-port inputs (enable, address, data and the per-lane byte-enable mask) are captured in a register stage. The array is updated from that stage on the following clock edge. Each write is split into lanes. Only lanes whose mask bit is set are stored, and the other lanes keep what they held before.

`DATA_W` selects the write width: 16, 18, 32 or 36 bits. Widths that divide by nine use 9-bit lanes, which leaves room for a parity or tag bit per byte. The other widths use 8-bit lanes. `RDW_MODE` chooses what the read port returns when its registered address matches the registered write address in the same cycle:
- the merged new word;
- the word stored before the write;
- an undefined value. When `DC_AS_OLD` is set, this mode returns the old word instead.

When `BE_USED` is cleared, the mask input is ignored and every write stores the full word.

Top module: `bytelane_ram`

## Requirements
- R1: A lane is stored only when the captured write enable is 1 and that lane's captured mask bit is 1. Lanes whose mask bit is 0 keep their previous contents.
- R2: Mask bit i controls lane i. Lane 0 is the least significant lane. Lanes are 8 bits wide when DATA_W is 16 or 32 (bit i covers data[8i+7:8i]). Lanes are 9 bits wide when DATA_W is 18 or 36 (bit i covers data[9i+8:9i]).
- R3: The mask has 2 bits for widths 16 and 18 and 4 bits for widths 32 and 36. Every mask value is legal: all zeros writes nothing, and all ones writes the whole word.
- R4: With BE_USED = 0, wr_be_i has no effect and every write with wr_en_i = 1 stores every lane.
- R5: Inputs sampled at clock edge k take effect at edge k+1, when the array is written and rd_data_o is loaded. A read sampled at edge k+1 or later returns the word written by the write sampled at edge k.
- R6: When the read enable sampled at edge k is 0, rd_data_o keeps its value across edge k+1.
- R7: RDW_MODE = RDW_NEW_DATA, with the read and write sampled at the same edge and the same address: enabled lanes of rd_data_o show the new write data, and disabled lanes show the stored word.
- R8: RDW_MODE = RDW_OLD_DATA, same collision: rd_data_o shows the word stored before the write.
- R9: RDW_MODE = RDW_DONT_CARE, same collision: rd_data_o is all X. With DC_AS_OLD = 1 it shows the old word instead. In both cases the write still lands.
- R10: While rst_ni is low, rd_data_o is 0 and any captured write is discarded. The mask register has no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| wr_be_i | input | NUM_LANES | Per-lane write mask, active high, bit 0 = lowest lane |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
The bench drives each operation at a falling edge, so the design samples it at the next rising edge k, and rd_data_o carries the result after edge k+1. The bench therefore compares each operation's expected word at the falling edge two operations later, holding expected values in a two-entry queue. Collision, merge and hold results are predicted from a per-configuration model that applies operations in issue order: each read sees every write issued before it, and the write issued alongside it is resolved by the mode. Reset behaviour is checked one falling edge after release, and the discarded write is checked with a read two operations later.

// File: rtl/bytelane_ram_pkg.sv
package bytelane_ram_pkg;

  typedef enum logic [1:0] {
    RDW_NEW_DATA  = 2'd0,
    RDW_OLD_DATA  = 2'd1,
    RDW_DONT_CARE = 2'd2
  } rdw_mode_e;

  // 9-bit lanes for widths carrying an extra bit per byte
  function automatic int lane_w(int dw);
    return (dw % 9 == 0) ? 9 : 8;
  endfunction

  function automatic int lanes(int dw);
    return dw / lane_w(dw);
  endfunction

endpackage

// File: rtl/brl_wr_stage.sv
module brl_wr_stage #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 36,
  parameter int NUM_LANES = 4,
  parameter bit BE_USED   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_LANES-1:0] wr_be_i,
  output logic                 wr_en_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic [NUM_LANES-1:0] wr_be_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_en_o <= 1'b0;
    else         wr_en_o <= wr_en_i;
  end

  always_ff @(posedge clk_i) begin
    wr_addr_o <= wr_addr_i;
    wr_data_o <= wr_data_i;
  end

  // mask register: load only, no clear
  if (BE_USED) begin : g_be_reg
    always_ff @(posedge clk_i) wr_be_o <= wr_be_i;
  end else begin : g_be_ones
    assign wr_be_o = '1;
  end

endmodule

// File: rtl/brl_mem_array.sv
module brl_mem_array #(
  parameter int ADDR_W    = 8,
  parameter int LANE_W    = 9,
  parameter int NUM_LANES = 4,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_LANES-1:0] wbe_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [DATA_W-1:0]    rdata_o
);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end

endmodule

// File: rtl/brl_rdw_sel.sv
module brl_rdw_sel
  import bytelane_ram_pkg::*;
#(
  parameter int        LANE_W    = 9,
  parameter int        NUM_LANES = 4,
  parameter rdw_mode_e RDW_MODE  = RDW_NEW_DATA,
  parameter bit        DC_AS_OLD = 1'b0,
  localparam int       DATA_W    = LANE_W * NUM_LANES
) (
  input  logic                 collide_i,
  input  logic [DATA_W-1:0]    mem_word_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_LANES-1:0] wr_be_i,
  output logic [DATA_W-1:0]    rd_word_o
);

  if (RDW_MODE == RDW_NEW_DATA) begin : g_new
    // per-lane forward: enabled lanes take the incoming word
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign rd_word_o[l*LANE_W +: LANE_W] = (collide_i && wr_be_i[l])
                                           ? wr_data_i[l*LANE_W +: LANE_W]
                                           : mem_word_i[l*LANE_W +: LANE_W];
    end
  end else if (RDW_MODE == RDW_OLD_DATA || DC_AS_OLD) begin : g_old
    assign rd_word_o = mem_word_i;
  end else begin : g_dc
    assign rd_word_o = collide_i ? {DATA_W{1'bx}} : mem_word_i;
  end

endmodule

// File: rtl/bytelane_ram.sv
module bytelane_ram
  import bytelane_ram_pkg::*;
#(
  parameter int        DATA_W    = 36,
  parameter int        ADDR_W    = 8,
  parameter rdw_mode_e RDW_MODE  = RDW_NEW_DATA,
  parameter bit        BE_USED   = 1'b1,
  parameter bit        DC_AS_OLD = 1'b0,
  localparam int       LANE_W    = lane_w(DATA_W),
  localparam int       NUM_LANES = DATA_W / LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_LANES-1:0] wr_be_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  logic                 wr_en_q;
  logic [ADDR_W-1:0]    wr_addr_q;
  logic [DATA_W-1:0]    wr_data_q;
  logic [NUM_LANES-1:0] wr_be_q;
  logic                 rd_en_q;
  logic [ADDR_W-1:0]    rd_addr_q;
  logic [DATA_W-1:0]    mem_word;
  logic [DATA_W-1:0]    sel_word;
  logic                 collide;

  brl_wr_stage #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_LANES(NUM_LANES),
    .BE_USED  (BE_USED)
  ) i_wr_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wr_be_i  (wr_be_i),
    .wr_en_o  (wr_en_q),
    .wr_addr_o(wr_addr_q),
    .wr_data_o(wr_data_q),
    .wr_be_o  (wr_be_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_en_q <= 1'b0;
    else         rd_en_q <= rd_en_i;
  end

  always_ff @(posedge clk_i) rd_addr_q <= rd_addr_i;

  brl_mem_array #(
    .ADDR_W   (ADDR_W),
    .LANE_W   (LANE_W),
    .NUM_LANES(NUM_LANES)
  ) i_mem_array (
    .clk_i  (clk_i),
    .we_i   (wr_en_q),
    .waddr_i(wr_addr_q),
    .wdata_i(wr_data_q),
    .wbe_i  (wr_be_q),
    .raddr_i(rd_addr_q),
    .rdata_o(mem_word)
  );

  assign collide = wr_en_q && rd_en_q && (wr_addr_q == rd_addr_q);

  brl_rdw_sel #(
    .LANE_W   (LANE_W),
    .NUM_LANES(NUM_LANES),
    .RDW_MODE (RDW_MODE),
    .DC_AS_OLD(DC_AS_OLD)
  ) i_rdw_sel (
    .collide_i (collide),
    .mem_word_i(mem_word),
    .wr_data_i (wr_data_q),
    .wr_be_i   (wr_be_q),
    .rd_word_o (sel_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_q) rd_data_o <= sel_word;
  end

endmodule

// File: rtl/bytelane_ram_chk.sv
module bytelane_ram_chk
  import bytelane_ram_pkg::*;
#(
  parameter int        DATA_W    = 36,
  parameter int        ADDR_W    = 8,
  parameter rdw_mode_e RDW_MODE  = RDW_NEW_DATA,
  parameter bit        BE_USED   = 1'b1,
  localparam int       LANE_W    = lane_w(DATA_W),
  localparam int       NUM_LANES = DATA_W / LANE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    wr_addr_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic [NUM_LANES-1:0] wr_be_i,
  input logic                 rd_en_i,
  input logic [ADDR_W-1:0]    rd_addr_i,
  input logic [DATA_W-1:0]    rd_data_o
);

  logic              wr_en_d, rd_en_d, collide_d;
  logic [ADDR_W-1:0] wr_addr_d, rd_addr_d;
  logic [DATA_W-1:0] wr_data_d, mask_n, mask_d;

  always_comb begin
    for (int b = 0; b < DATA_W; b++) mask_n[b] = BE_USED ? wr_be_i[b / LANE_W] : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_d <= 1'b0;
      rd_en_d <= 1'b0;
    end else begin
      wr_en_d <= wr_en_i;
      rd_en_d <= rd_en_i;
    end
  end

  always_ff @(posedge clk_i) begin
    wr_addr_d <= wr_addr_i;
    rd_addr_d <= rd_addr_i;
    wr_data_d <= wr_data_i;
    mask_d    <= mask_n;
  end

  assign collide_d = wr_en_d && rd_en_d && (wr_addr_d == rd_addr_d);

  p_reset_clear_r10: assert property (@(posedge clk_i)
    !rst_ni |=> rd_data_o == '0);

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_d |=> $stable(rd_data_o));

  p_fwd_new_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RDW_MODE == RDW_NEW_DATA && collide_d)
    |=> (((rd_data_o ^ $past(wr_data_d)) & $past(mask_d)) == '0));

  p_write_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_d) && rd_en_d && rd_addr_d == $past(wr_addr_d) && !collide_d)
    |=> (((rd_data_o ^ $past(wr_data_d, 2)) & $past(mask_d, 2)) == '0));

endmodule

bind bytelane_ram bytelane_ram_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .RDW_MODE(RDW_MODE),
  .BE_USED (BE_USED)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .wr_be_i  (wr_be_i),
  .rd_en_i  (rd_en_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o)
);

// File: tb/test_bytelane_ram.sv
module test_bytelane_ram;
  import bytelane_ram_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 3;
  localparam int NW         = 1 << AW;
  localparam int NCFG       = 14;

  // cfg 0..11: width x mode grid; 12: 32b mask ignored; 13: 18b don't-care as old
  function automatic int cfg_w(int c);
    if (c == 12) return 32;
    if (c == 13) return 18;
    case (c / 3)
      0: return 16;
      1: return 18;
      2: return 32;
      default: return 36;
    endcase
  endfunction
  function automatic int cfg_mode(int c);
    if (c == 12) return 0;
    if (c == 13) return 2;
    return c % 3;
  endfunction
  function automatic bit cfg_be(int c);
    return c != 12;
  endfunction
  function automatic bit cfg_safe(int c);
    return c == 13;
  endfunction

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we = 1'b0, re = 1'b0;
  logic [AW-1:0]     wa = '0, ra = '0;
  logic [35:0]       wd = '0;
  logic [3:0]        be = '0;
  logic [NCFG-1:0][35:0] rdq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    localparam int W  = cfg_w(c);
    localparam int NL = lanes(W);
    logic [W-1:0] q;
    bytelane_ram #(
      .DATA_W   (W),
      .ADDR_W   (AW),
      .RDW_MODE (rdw_mode_e'(cfg_mode(c))),
      .BE_USED  (cfg_be(c)),
      .DC_AS_OLD(cfg_safe(c))
    ) i_bytelane_ram (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .wr_en_i  (we),
      .wr_addr_i(wa),
      .wr_data_i(wd[W-1:0]),
      .wr_be_i  (be[NL-1:0]),
      .rd_en_i  (re),
      .rd_addr_i(ra),
      .rd_data_o(q)
    );
    assign rdq[c] = 36'(q);
  end

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  logic [35:0] ref_mem [NCFG][NW];
  logic [35:0] exp_last [NCFG];
  bit          exp_last_ok [NCFG];
  logic [35:0] pend_val [2][NCFG];
  bit          pend_ok  [2][NCFG];
  string       pend_tag [2][NCFG];

  function automatic logic [35:0] width_mask(int c);
    logic [35:0] m = '0;
    for (int b = 0; b < 36; b++) m[b] = (b < cfg_w(c));
    return m;
  endfunction

  // R2/R3/R4: lane i spans lw bits from i*lw; mask bits beyond lane count unused
  function automatic logic [35:0] lane_mask(int c, logic [3:0] bev);
    int lw = (cfg_w(c) % 9 == 0) ? 9 : 8;
    logic [35:0] m = '0;
    for (int b = 0; b < 36; b++)
      m[b] = (b < cfg_w(c)) && (cfg_be(c) ? bev[b / lw] : 1'b1);
    return m;
  endfunction

  task automatic check_val(int c, logic [35:0] exp, string tag);
    n_cmp++;
    if (rdq[c] !== exp) begin
      n_bad++;
      $display("FAIL %s cfg %0d: rd_data %h expected %h", tag, c, rdq[c], exp);
    end
  endtask

  task automatic clear_pipe();
    for (int c = 0; c < NCFG; c++) begin
      exp_last[c] = '0;
      exp_last_ok[c] = 1'b1;
      pend_ok[0][c] = 1'b0;
      pend_ok[1][c] = 1'b0;
    end
  endtask

  // one op per cycle; result due after the second rising edge (R5)
  task automatic op(input bit we_v, input int wa_v, input logic [35:0] wd_v,
                    input logic [3:0] be_v, input bit re_v, input int ra_v);
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      if (pend_ok[1][c]) check_val(c, pend_val[1][c], pend_tag[1][c]);
      pend_ok[1][c]  = pend_ok[0][c];
      pend_val[1][c] = pend_val[0][c];
      pend_tag[1][c] = pend_tag[0][c];
    end
    we = we_v; wa = AW'(wa_v); wd = wd_v; be = be_v; re = re_v; ra = AW'(ra_v);
    for (int c = 0; c < NCFG; c++) begin
      logic [35:0] wm = width_mask(c);
      logic [35:0] lm = lane_mask(c, be_v);
      logic [35:0] old = ref_mem[c][ra_v] & wm;
      bit collide = we_v && re_v && (wa_v == ra_v);
      if (!re_v) begin
        pend_tag[0][c] = "R6";
      end else if (collide) begin
        case (cfg_mode(c))
          0: begin exp_last[c] = (wd_v & lm) | (old & ~lm); exp_last_ok[c] = 1'b1; pend_tag[0][c] = "R7"; end
          1: begin exp_last[c] = old; exp_last_ok[c] = 1'b1; pend_tag[0][c] = "R8"; end
          default: begin
            exp_last[c] = old;
            exp_last_ok[c] = cfg_safe(c);
            pend_tag[0][c] = "R9";
          end
        endcase
      end else begin
        exp_last[c] = old;
        exp_last_ok[c] = 1'b1;
        pend_tag[0][c] = (c == 12) ? "R4" : "R1";
      end
      pend_val[0][c] = exp_last[c];
      pend_ok[0][c]  = exp_last_ok[c];
      if (we_v) ref_mem[c][wa_v] = ((wd_v & lm) | (ref_mem[c][wa_v] & ~lm)) & wm;
    end
  endtask

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  initial begin
    clear_pipe();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R10: output cleared by reset
    for (int c = 0; c < NCFG; c++) check_val(c, '0, "R10");

    // fill every word with a full mask
    for (int a = 0; a < NW; a++) op(1, a, rnd36(), 4'hF, 0, 0);

    // R3: every mask value, colliding read then clean read of the same word
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < NW; a++) begin
        op(1, a, rnd36(), 4'(m), 1, a);
        op(0, 0, '0, 4'h0, 1, a);
      end
    end

    // R5: read issued one cycle after the write to the same word
    for (int a = 0; a < NW; a++) begin
      op(1, a, rnd36(), 4'($urandom), 0, 0);
      op(0, 0, '0, 4'h0, 1, a);
    end

    // mixed traffic with frequent collisions and idle reads (R6)
    for (int i = 0; i < 2500; i++) begin
      int a = int'($urandom % NW);
      op(bit'($urandom % 2), a, rnd36(), 4'($urandom), ($urandom % 4) != 0,
         ($urandom % 2) ? a : int'($urandom % NW));
    end
    op(0, 0, '0, 4'h0, 0, 0);
    op(0, 0, '0, 4'h0, 0, 0);

    // R10: a captured write is dropped by reset
    @(negedge clk);
    we = 1'b1; wa = AW'(5); wd = rnd36(); be = 4'hF; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int c = 0; c < NCFG; c++) check_val(c, '0, "R10");
    clear_pipe();
    for (int c = 0; c < NCFG; c++) pend_tag[0][c] = "R10";
    op(0, 0, '0, 4'h0, 1, 5);
    for (int c = 0; c < NCFG; c++) pend_tag[0][c] = "R10";
    op(0, 0, '0, 4'h0, 0, 0);
    op(0, 0, '0, 4'h0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule